// File: doc/BRIEF.md
# Stack Machine Execution Core

This block is a small processor that runs programs written in a byte-coded stack instruction set. Every instruction passes through three states: fetch, decode and execute. Operands live on an internal stack of word-wide cells. A stack pointer register tracks that stack and holds the number of items it currently contains. Program bytes come from a synchronous instruction memory, which returns data one cycle after the address is presented. The core has no data memory other than the stack. Results leave the core only through the print instruction, which produces a one-cycle output strobe carrying a word.

The core starts at address 0 after reset and keeps running until one of three things happens: it executes the halt opcode, it meets an opcode it does not know, or it detects a fault. It traps instead of wrapping when an instruction needs more stack items than are present, when an instruction would push onto a full stack, or when a division has a zero divisor. After any stop, the program counter, the stack pointer and the fault code are frozen where the stop happened, so the surrounding system can read them.

Top module: `sm_core`

## Requirements
- R1: While rst_n is low, pc and sp read 0, and halted, fault and out_valid read 0. The core starts executing two clock cycles after rst_n rises.
- R2: Each instruction takes three cycles: fetch, decode and execute. A program of n executed instructions that ends in a halt raises halted 3n+2 cycles after rst_n rises. Opcodes are: 00 halt, 01 push, 02 pop, 03 add, 04 sub, 05 mul, 06 div, 07 dup, 08 swap, 09 over, 0A jmp, 0B jz, 0C print.
- R3: Push is two bytes long. Its second byte is zero-extended and pushed, and pc then advances by 2. Every other opcode except jmp and jz is one byte long.
- R4: Add, sub, mul and div pop two items and push one result. The left operand is the second item and the right operand is the top item. Results are taken modulo 2^DATA_W, and div gives the unsigned quotient.
- R5: Pop discards the top item. Dup pushes a copy of the top item. Swap exchanges the top two items. Over pushes a copy of the second item.
- R6: Jmp loads pc from its one-byte absolute target. Jz pops the top item and jumps to its target if that item is zero; otherwise pc advances by 2.
- R7: Print pops the top item and drives it on out_data while out_valid is high for exactly one cycle.
- R8: An instruction that finds fewer items on the stack than it needs sets fault to 1 (underflow). Pop, dup, jz and print need one item. The four arithmetic ops, swap and over need two.
- R9: Push, dup or over executed while sp equals DEPTH sets fault to 2 (overflow). sp never exceeds DEPTH.
- R10: Div with a zero top item sets fault to 3.
- R11: A fault, the halt opcode, or any unlisted opcode stops the core. halted then stays high, pc stays at the address of the stopping instruction, and the stack and outputs are left unchanged. Halt and unlisted opcodes leave fault at 0.
- R12: If an instruction meets more than one fault condition, underflow is reported ahead of overflow and division by zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_data | input | 8 | Instruction byte, returned one cycle after imem_addr |
| imem_addr | output | PC_W | Instruction memory read address |
| pc | output | PC_W | Address of the current instruction |
| sp | output | clog2(DEPTH+1) | Number of items on the stack |
| halted | output | 1 | Core has stopped |
| fault | output | 2 | 0 none, 1 underflow, 2 overflow, 3 divide by zero |
| out_valid | output | 1 | One-cycle strobe for a printed value |
| out_data | output | DATA_W | Printed value |

## Verification
Several properties are checked on every cycle by the assertions. Once halted is high it stays high, and pc stays frozen. A print strobe never lasts more than one cycle. Any nonzero fault implies halted. The stack pointer moves by at most one item per cycle and never goes past DEPTH. The operand order of the arithmetic ops, the jz decision, the fault priority, the three-cycle instruction timing and the values that get printed can only be shown by the bench's programs. Those programs include a counting loop that computes a factorial and ends with its result on the print strobe.

// File: rtl/sm_pkg.sv
package sm_pkg;

  typedef enum logic [7:0] {
    OP_HALT  = 8'h00,
    OP_PUSH  = 8'h01,
    OP_POP   = 8'h02,
    OP_ADD   = 8'h03,
    OP_SUB   = 8'h04,
    OP_MUL   = 8'h05,
    OP_DIV   = 8'h06,
    OP_DUP   = 8'h07,
    OP_SWAP  = 8'h08,
    OP_OVER  = 8'h09,
    OP_JMP   = 8'h0A,
    OP_JZ    = 8'h0B,
    OP_PRINT = 8'h0C
  } opcode_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_UNDER = 2'd1,
    FLT_OVER  = 2'd2,
    FLT_DIVZ  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_HALT
  } state_e;

endpackage

// File: rtl/sm_rst_sync.sv
module sm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  // assert at once, release after two edges
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/sm_alu.sv
module sm_alu
  import sm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [7:0]        op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] res,
  output logic              div_zero
);

  always_comb begin
    div_zero = (rhs == '0);
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = lhs * rhs;
      OP_DIV:  res = div_zero ? '0 : lhs / rhs;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/sm_stack.sv
module sm_stack #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [SP_W-1:0]   nsp,
  input  logic              wr_top,
  input  logic [DATA_W-1:0] top_val,
  input  logic              wr_sec,
  input  logic [DATA_W-1:0] sec_val,
  output logic [SP_W-1:0]   sp,
  output logic [DATA_W-1:0] top,
  output logic [DATA_W-1:0] sec
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SLOTS = 1 << IDX_W;

  logic [DATA_W-1:0] cells [SLOTS];
  logic [SP_W-1:0]   sp_q;
  logic [IDX_W-1:0]  top_slot, sec_slot, rd_top, rd_sec;

  function automatic logic [IDX_W-1:0] slot(input logic [SP_W-1:0] n,
                                            input logic [SP_W-1:0] back);
    logic [SP_W-1:0] d;
    d = n - back;
    return d[IDX_W-1:0];
  endfunction

  always_comb begin
    top_slot = slot(nsp, SP_W'(1));
    sec_slot = slot(nsp, SP_W'(2));
    rd_top   = slot(sp_q, SP_W'(1));
    rd_sec   = slot(sp_q, SP_W'(2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp_q <= '0;
    else if (upd_en) sp_q <= nsp;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (upd_en && wr_top && top_slot == IDX_W'(i))      cells[i] <= top_val;
      else if (upd_en && wr_sec && sec_slot == IDX_W'(i)) cells[i] <= sec_val;
    end
  end

  assign sp  = sp_q;
  assign top = cells[rd_top];
  assign sec = cells[rd_sec];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH)); // R9

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sp_q == $past(sp_q) || sp_q == $past(sp_q) + SP_W'(1) ||
              sp_q == $past(sp_q) - SP_W'(1))); // R5

endmodule

// File: rtl/sm_core.sv
module sm_core
  import sm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int PC_W   = 8,
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        imem_data,
  output logic [PC_W-1:0]   imem_addr,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp,
  output logic              halted,
  output logic [1:0]        fault,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic              rst_i;
  state_e            state_q, state_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic              pc_en;
  logic [7:0]        ir_q;
  logic              ir_en;
  fault_e            flt_q, flt_d;
  logic              flt_en;
  logic              ov_q, ov_d;
  logic [DATA_W-1:0] od_q;
  logic              od_en;

  logic              st_upd, wr_top, wr_sec;
  logic [SP_W-1:0]   sp_w, nsp;
  logic [DATA_W-1:0] top_w, sec_w, top_val, sec_val, alu_res;
  logic              dz;

  logic [1:0]        need;
  logic              grows, known, under, over;
  logic [PC_W-1:0]   len, tgt;
  logic [DATA_W-1:0] imm;

  sm_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_i));

  sm_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_i), .upd_en(st_upd), .nsp(nsp),
    .wr_top(wr_top), .top_val(top_val), .wr_sec(wr_sec), .sec_val(sec_val),
    .sp(sp_w), .top(top_w), .sec(sec_w)
  );

  sm_alu #(.DATA_W(DATA_W)) u_alu (
    .op(ir_q), .lhs(sec_w), .rhs(top_w), .res(alu_res), .div_zero(dz)
  );

  // opcode attributes: items needed, growth, length
  always_comb begin
    need  = 2'd0;
    grows = 1'b0;
    known = 1'b1;
    len   = PC_W'(1);
    case (ir_q)
      OP_HALT: ;
      OP_PUSH: begin grows = 1'b1; len = PC_W'(2); end
      OP_POP, OP_PRINT: need = 2'd1;
      OP_DUP:  begin need = 2'd1; grows = 1'b1; end
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_SWAP: need = 2'd2;
      OP_OVER: begin need = 2'd2; grows = 1'b1; end
      OP_JMP:  len = PC_W'(2);
      OP_JZ:   begin need = 2'd1; len = PC_W'(2); end
      default: known = 1'b0;
    endcase
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    pc_en   = 1'b0;
    ir_en   = 1'b0;
    flt_d   = flt_q;
    flt_en  = 1'b0;
    ov_d    = 1'b0;
    od_en   = 1'b0;
    st_upd  = 1'b0;
    nsp     = sp_w;
    wr_top  = 1'b0;
    wr_sec  = 1'b0;
    top_val = top_w;
    sec_val = sec_w;
    under   = sp_w < SP_W'(need);
    over    = grows && (sp_w == SP_W'(DEPTH));
    imm     = DATA_W'(imem_data);
    tgt     = PC_W'(imem_data);
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin ir_en = 1'b1; state_d = ST_EXEC; end
      ST_EXEC: begin
        if (!known || ir_q == OP_HALT) begin
          state_d = ST_HALT;
        end else if (under) begin
          flt_d = FLT_UNDER; flt_en = 1'b1; state_d = ST_HALT;
        end else if (over) begin
          flt_d = FLT_OVER;  flt_en = 1'b1; state_d = ST_HALT;
        end else if (ir_q == OP_DIV && dz) begin
          flt_d = FLT_DIVZ;  flt_en = 1'b1; state_d = ST_HALT;
        end else begin
          state_d = ST_FETCH;
          pc_en   = 1'b1;
          pc_d    = pc_q + len;
          st_upd  = 1'b1;
          case (ir_q)
            OP_PUSH:  begin nsp = sp_w + SP_W'(1); wr_top = 1'b1; top_val = imm; end
            OP_POP:   nsp = sp_w - SP_W'(1);
            OP_PRINT: begin nsp = sp_w - SP_W'(1); ov_d = 1'b1; od_en = 1'b1; end
            OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
              nsp = sp_w - SP_W'(1); wr_top = 1'b1; top_val = alu_res;
            end
            OP_DUP:   begin nsp = sp_w + SP_W'(1); wr_top = 1'b1; top_val = top_w; end
            OP_SWAP:  begin
              wr_top = 1'b1; top_val = sec_w; wr_sec = 1'b1; sec_val = top_w;
            end
            OP_OVER:  begin nsp = sp_w + SP_W'(1); wr_top = 1'b1; top_val = sec_w; end
            OP_JMP:   pc_d = tgt;
            OP_JZ:    begin
              nsp = sp_w - SP_W'(1);
              if (top_w == '0) pc_d = tgt;
            end
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      flt_q   <= FLT_NONE;
      ov_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ov_q    <= ov_d;
      if (pc_en)  pc_q  <= pc_d;
      if (flt_en) flt_q <= flt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ir_en) ir_q <= imem_data;
    if (od_en) od_q <= top_w;
  end

  assign imem_addr = (state_q == ST_FETCH) ? pc_q : pc_q + PC_W'(1);
  assign pc        = pc_q;
  assign sp        = sp_w;
  assign halted    = (state_q == ST_HALT);
  assign fault     = flt_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    halted |=> halted); // R11

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_i)
    halted |=> $stable(pc_q)); // R11

  AST_PRINT_PULSE: assert property (@(posedge clk) disable iff (!rst_i)
    ov_q |=> !ov_q); // R7

  AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_i)
    (flt_q != FLT_NONE) |-> halted); // R8

endmodule

// File: tb/sm_core_bench.sv
`timescale 1ns/1ps
module sm_core_bench;

  logic        clk;
  logic        rst_n;
  logic [7:0]  imem_data;
  logic [7:0]  imem_addr;
  logic [7:0]  pc;
  logic [3:0]  sp;
  logic        halted;
  logic [1:0]  fault;
  logic        out_valid;
  logic [15:0] out_data;

  logic [7:0]  mem [256];
  int          errors = 0;
  int          checks = 0;
  int          pcount;
  logic [15:0] pfirst, plast;
  int          run_len = 0;
  int          max_run = 0;

  sm_core u_sm_core (
    .clk(clk), .rst_n(rst_n), .imem_data(imem_data), .imem_addr(imem_addr),
    .pc(pc), .sp(sp), .halted(halted), .fault(fault),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) imem_data <= mem[imem_addr];

  always @(negedge clk) begin
    if (!rst_n) begin
      pcount = 0;
    end else if (out_valid) begin
      if (pcount == 0) pfirst = out_data;
      plast  = out_data;
      pcount = pcount + 1;
    end
    if (out_valid) run_len = run_len + 1;
    else           run_len = 0;
    if (run_len > max_run) max_run = run_len;
  end

  // program bytes: byte i at code[8*i +: 8] (address 0 at the right)
  typedef struct packed {
    logic [159:0] code;
    logic [7:0]   pc;
    logic [3:0]   sp;
    logic [1:0]   flt;
    logic [7:0]   n;
    logic [3:0]   np;
    logic [15:0]  first;
    logic [15:0]  last;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{160'h000C0403010701,       8'd6,  4'd0, 2'd0, 8'd5,  4'd1, 16'd4,   16'd4},
    '{160'h000C0606011401,       8'd6,  4'd0, 2'd0, 8'd5,  4'd1, 16'd3,   16'd3},
    '{160'h000C0304010506010501, 8'd9,  4'd0, 2'd0, 8'd7,  4'd1, 16'd34,  16'd34},
    '{160'h000C0C0802010101,     8'd7,  4'd0, 2'd0, 8'd6,  4'd2, 16'd1,   16'd2},
    '{160'h000C030C0904010901,   8'd8,  4'd0, 2'd0, 8'd7,  4'd2, 16'd9,   16'd13},
    '{160'h000C03070301,         8'd5,  4'd0, 2'd0, 8'd5,  4'd1, 16'd6,   16'd6},
    '{160'h000C0101070B0001,     8'd7,  4'd0, 2'd0, 8'd3,  4'd0, 16'd0,   16'd0},
    '{160'h000C0101070B0501,     8'd7,  4'd0, 2'd0, 8'd5,  4'd1, 16'd1,   16'd1},
    '{160'h000105040A,           8'd4,  4'd0, 2'd0, 8'd2,  4'd0, 16'd0,   16'd0},
    '{160'h02,                   8'd0,  4'd0, 2'd1, 8'd1,  4'd0, 16'd0,   16'd0},
    '{160'h080101,               8'd2,  4'd1, 2'd1, 8'd2,  4'd0, 16'd0,   16'd0},
    '{160'h0600010501,           8'd4,  4'd2, 2'd3, 8'd3,  4'd0, 16'd0,   16'd0},
    '{160'h030201,               8'd2,  4'd1, 2'd1, 8'd2,  4'd0, 16'd0,   16'd0},
    '{160'hFF0301,               8'd2,  4'd1, 2'd0, 8'd2,  4'd0, 16'd0,   16'd0},
    '{160'h000C0402010101,       8'd6,  4'd0, 2'd0, 8'd5,  4'd1, 16'hFFFF, 16'hFFFF},
    '{160'h060001,               8'd2,  4'd1, 2'd1, 8'd2,  4'd0, 16'd0,   16'd0},
    '{160'h010101010101010101010101010101010101, 8'd16, 4'd8, 2'd2, 8'd9, 4'd0, 16'd0, 16'd0},
    '{160'h000C02040A04010108050908100B0705010101, 8'd18, 4'd0, 2'd0, 8'd52, 4'd1, 16'd120, 16'd120}
  };

  // 0,1 R4 sub/div; 2 R3 push length; 3-5 R5 stack ops; 6-8 R6 jumps;
  // 9,10,12 R8 underflow; 11 R10; 13 R11 unknown opcode; 14 R4 wrap;
  // 15 R12 priority; 16 R9 overflow; 17 R7 factorial loop
  localparam string TAG [NV] = '{"R4", "R4", "R3", "R5", "R5", "R5", "R6", "R6", "R6",
                                 "R8", "R8", "R10", "R8", "R11", "R4", "R12", "R9", "R7"};

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic load(input int k);
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    for (int b = 0; b < 20; b++) mem[b] = VEC[k].code[8*b +: 8];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    int cnt;
    logic [7:0] pc_hold;
    int pc_cnt;
    rst_n = 1'b0;
    load(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pc == 8'd0,     "R1", "pc in reset", pc, 0);
    check(sp == 4'd0,     "R1", "sp in reset", sp, 0);
    check(halted == 1'b0, "R1", "halted in reset", halted, 0);
    check(fault == 2'd0,  "R1", "fault in reset", fault, 0);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);

    for (int k = 0; k < NV; k++) begin
      rst_n = 1'b0;
      load(k);
      @(negedge clk);
      rst_n = 1'b1;
      cnt = 0;
      while (!halted && cnt < 1000) begin
        @(negedge clk);
        cnt = cnt + 1;
      end
      check(cnt == 3 * int'(VEC[k].n) + 2, "R2", $sformatf("cycles prog %0d", k),
            cnt, 3 * int'(VEC[k].n) + 2);
      check(pc == VEC[k].pc,       TAG[k], $sformatf("pc prog %0d", k), pc, VEC[k].pc);
      check(sp == VEC[k].sp,       TAG[k], $sformatf("sp prog %0d", k), sp, VEC[k].sp);
      check(fault == VEC[k].flt,   TAG[k], $sformatf("fault prog %0d", k), fault, VEC[k].flt);
      check(pcount == int'(VEC[k].np), TAG[k], $sformatf("prints prog %0d", k),
            pcount, VEC[k].np);
      if (VEC[k].np != 4'd0) begin
        check(pfirst == VEC[k].first, TAG[k], $sformatf("first print prog %0d", k),
              pfirst, VEC[k].first);
        check(plast == VEC[k].last, TAG[k], $sformatf("last print prog %0d", k),
              plast, VEC[k].last);
      end
      pc_hold = pc;
      pc_cnt  = pcount;
      repeat (6) @(negedge clk);
      check(halted == 1'b1 && pc == pc_hold, "R11", $sformatf("frozen pc prog %0d", k),
            pc, pc_hold);
      check(pcount == pc_cnt, "R11", $sformatf("no print after stop prog %0d", k),
            pcount, pc_cnt);
    end

    // R1 reset in the middle of the factorial loop
    rst_n = 1'b0;
    load(17);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(sp != 4'd0 || pc != 8'd0, "R1", "running before reset", pc, 1);
    rst_n = 1'b0;
    #1;
    check(pc == 8'd0 && sp == 4'd0, "R1", "pc/sp after mid-run reset", pc, 0);
    check(halted == 1'b0 && fault == 2'd0, "R1", "halted/fault after mid-run reset",
          halted, 0);
    @(negedge clk);

    // R7 strobe width over every run
    check(max_run == 1, "R7", "out_valid pulse width", max_run, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule